// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a small stored cursor image over a stream of display pixels on their way to the output. Each pixel arrives with its screen coordinates. When the pixel falls inside the 32x32 cursor window, its colour is replaced by a composite of the cursor image and the underlying pixel. All other pixels leave unchanged. The cursor store holds one image per cursor identifier. Each image has one of two formats. The first is a monochrome format, where every cursor pixel carries one AND bit and one XOR bit. The second is an alpha format, where every cursor pixel is a 32-bit word: the top byte is the blend weight and the low three bytes are the cursor colour.

Software prepares the identifier, X and Y values in staging registers. Writing these registers changes nothing on the screen. The staged values reach the overlay only when a show code is written to the control register. The control register also accepts a hide code and two codes for taking the cursor out of frame memory and putting it back. The cursor is composited only in the output path and never sits in frame memory, so these two codes leave the displayed state unchanged. The pixel path has a fixed latency of two cycles. The valid flag and the coordinates are delayed by the same amount, so they stay aligned with the pixel.

Top module: `cursor_overlay`

## Requirements
- R1: `out_valid`, `out_x` and `out_y` repeat `in_valid`, `in_x` and `in_y` exactly two clock cycles later. `out_valid` is low while reset is active and after reset until valid pixels have passed through.
- R2: After reset the cursor is hidden. While it is hidden, every output pixel equals its input pixel.
- R3: A register write with `reg_sel` = 0 (identifier), 1 (X) or 2 (Y) changes only a staging copy. The output does not change until the control register is written.
- R4: Writing the value 1 (show) with `reg_sel` = 3 copies the staged identifier, X and Y into the active state and shows the cursor.
- R5: Writing the value 0 (hide) with `reg_sel` = 3 hides the cursor, so that pixels pass through unchanged.
- R6: A control write of 2 (out of frame memory), of 3 (back into frame memory) or of any value above 3 changes neither the shown/hidden state nor the active identifier or position.
- R7: A pixel is covered when cx <= x < cx+32 and cy <= y < cy+32. The comparison is evaluated in wider arithmetic, so a window that runs past the largest coordinate is clipped there and does not wrap to small coordinates. Uncovered pixels pass through.
- R8: In a monochrome image, bit 0 of the word is the AND bit and bit 1 is the XOR bit. The output is (background AND {24{AND bit}}) XOR {24{XOR bit}}.
- R9: In an alpha image, bits 31:24 are the weight a and bits 23:0 are the cursor colour c. Each 8-bit channel of the output is (a*c + (255-a)*b + 128) >> 8, where b is the background channel.
- R10: An image write stores `img_data` at word address dy*32+dx of identifier `img_id`. The write also sets that identifier's format from `img_fmt` (1 = alpha, 0 = monochrome). The last write to an identifier decides its format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 identifier, 1 X, 2 Y, 3 control |
| reg_wdata | input | 32 | Register write data |
| img_we | input | 1 | Cursor image write strobe |
| img_id | input | ID_W | Identifier of the image being written |
| img_addr | input | 10 | Image word address, dy*32+dx |
| img_data | input | 32 | Image word |
| img_fmt | input | 1 | Format of the image: 1 alpha, 0 monochrome |
| in_valid | input | 1 | Input pixel valid |
| in_x | input | COORD_W | Input pixel X coordinate |
| in_y | input | COORD_W | Input pixel Y coordinate |
| in_pix | input | 24 | Input pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | COORD_W | Output pixel X coordinate |
| out_y | output | COORD_W | Output pixel Y coordinate |
| out_pix | output | 24 | Composited pixel colour |

## Verification
An active state that takes up staged values too early or too late shows up on the very next covered pixel. The pixel then appears at the old or the new window position, and the mismatch is visible two cycles after that pixel enters. A wrong format flag or a wrong image address changes the colour of individual covered pixels, so the bench probes corners, edges and mid-window points for both formats, with blend weights of zero, full and middle values. An error in the window compare shows up on pixels just outside each edge and on the window clipped at the last coordinate. A stall or skew in the pipeline shows up as a coordinate or arrival-cycle mismatch on every pixel.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CUR_BITS = 5;
  localparam int CUR_DIM  = 1 << CUR_BITS;
  localparam int IMG_AW   = 2 * CUR_BITS;
  localparam int CH_W     = 8;
  localparam int NUM_CH   = 3;
  localparam int PIX_W    = CH_W * NUM_CH;
  localparam int WORD_W   = 32;

  typedef enum logic [1:0] {
    SEL_ID  = 2'd0,
    SEL_X   = 2'd1,
    SEL_Y   = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  localparam logic [WORD_W-1:0] CTL_HIDE = 32'd0;
  localparam logic [WORD_W-1:0] CTL_SHOW = 32'd1;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ID_W    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [ID_W-1:0]    act_id,
  output logic [COORD_W-1:0] act_x,
  output logic [COORD_W-1:0] act_y,
  output logic               shown
);
  logic [ID_W-1:0]    stg_id_q, stg_id_d, act_id_q, act_id_d;
  logic [COORD_W-1:0] stg_x_q, stg_x_d, stg_y_q, stg_y_d;
  logic [COORD_W-1:0] act_x_q, act_x_d, act_y_q, act_y_d;
  logic               shown_q, shown_d;
  logic               ctl_wr;

  assign ctl_wr = reg_we && (reg_sel == SEL_CTL);

  always_comb begin
    stg_id_d = stg_id_q;
    stg_x_d  = stg_x_q;
    stg_y_d  = stg_y_q;
    act_id_d = act_id_q;
    act_x_d  = act_x_q;
    act_y_d  = act_y_q;
    shown_d  = shown_q;
    if (reg_we && reg_sel == SEL_ID) stg_id_d = reg_wdata[ID_W-1:0];
    if (reg_we && reg_sel == SEL_X)  stg_x_d  = reg_wdata[COORD_W-1:0];
    if (reg_we && reg_sel == SEL_Y)  stg_y_d  = reg_wdata[COORD_W-1:0];
    if (ctl_wr && reg_wdata == CTL_SHOW) begin
      act_id_d = stg_id_q;
      act_x_d  = stg_x_q;
      act_y_d  = stg_y_q;
      shown_d  = 1'b1;
    end else if (ctl_wr && reg_wdata == CTL_HIDE) begin
      shown_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_id_q <= '0;
      stg_x_q  <= '0;
      stg_y_q  <= '0;
      act_id_q <= '0;
      act_x_q  <= '0;
      act_y_q  <= '0;
      shown_q  <= 1'b0;
    end else begin
      stg_id_q <= stg_id_d;
      stg_x_q  <= stg_x_d;
      stg_y_q  <= stg_y_d;
      act_id_q <= act_id_d;
      act_x_q  <= act_x_d;
      act_y_q  <= act_y_d;
      shown_q  <= shown_d;
    end
  end

  assign act_id = act_id_q;
  assign act_x  = act_x_q;
  assign act_y  = act_y_q;
  assign shown  = shown_q;
endmodule

// File: rtl/cursor_store.sv
module cursor_store
  import cursor_pkg::*;
#(
  parameter int NUM_IDS = 2,
  parameter int ID_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [IMG_AW-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_fmt,
  input  logic              rd_en,
  input  logic [ID_W-1:0]   rd_id,
  input  logic [IMG_AW-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_fmt
);
  localparam int DEPTH = NUM_IDS << IMG_AW;

  logic [WORD_W-1:0]  mem [0:DEPTH-1];
  logic [NUM_IDS-1:0] fmt_q, fmt_d;
  logic [WORD_W-1:0]  rd_data_q;
  logic               rd_fmt_q;

  always_comb begin
    fmt_d = fmt_q;
    if (wr_en) fmt_d[wr_id] = wr_fmt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fmt_q <= '0;
    else        fmt_q <= fmt_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_id, wr_addr}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data_q <= mem[{rd_id, rd_addr}];
      rd_fmt_q  <= fmt_q[rd_id];
    end
  end

  assign rd_data = rd_data_q;
  assign rd_fmt  = rd_fmt_q;
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
  import cursor_pkg::*;
(
  input  logic [PIX_W-1:0]  bg,
  input  logic [WORD_W-1:0] word,
  input  logic              alpha_fmt,
  input  logic              hit,
  output logic [PIX_W-1:0]  pix
);
  logic [PIX_W-1:0] mono_pix;
  logic [PIX_W-1:0] alpha_pix;
  logic [CH_W-1:0]  wgt;

  assign wgt      = word[WORD_W-1 -: CH_W];
  assign mono_pix = (bg & {PIX_W{word[0]}}) ^ {PIX_W{word[1]}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [2*CH_W:0] acc;
    assign acc = (2*CH_W+1)'(wgt) * (2*CH_W+1)'(word[c*CH_W +: CH_W])
               + (2*CH_W+1)'(8'd255 - wgt) * (2*CH_W+1)'(bg[c*CH_W +: CH_W])
               + (2*CH_W+1)'(128);
    assign alpha_pix[c*CH_W +: CH_W] = acc[2*CH_W-1:CH_W];
  end

  always_comb begin
    if (!hit)          pix = bg;
    else if (alpha_fmt) pix = alpha_pix;
    else               pix = mono_pix;
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int NUM_IDS = 2,
  localparam int ID_W   = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [WORD_W-1:0]  reg_wdata,
  input  logic               img_we,
  input  logic [ID_W-1:0]    img_id,
  input  logic [IMG_AW-1:0]  img_addr,
  input  logic [WORD_W-1:0]  img_data,
  input  logic               img_fmt,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [PIX_W-1:0]   in_pix,
  output logic               out_valid,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y,
  output logic [PIX_W-1:0]   out_pix
);
  localparam logic [COORD_W:0] DIM_EXT = (COORD_W+1)'(CUR_DIM);

  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic [ID_W-1:0]    act_id;
  logic [COORD_W-1:0] act_x, act_y;
  logic               shown;

  cursor_regs #(.COORD_W(COORD_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .act_id(act_id), .act_x(act_x), .act_y(act_y),
    .shown(shown)
  );

  logic                in_win_x, in_win_y, hit;
  logic [CUR_BITS-1:0] dx, dy;

  assign in_win_x = ({1'b0, in_x} >= {1'b0, act_x}) &&
                    ({1'b0, in_x} <  ({1'b0, act_x} + DIM_EXT));
  assign in_win_y = ({1'b0, in_y} >= {1'b0, act_y}) &&
                    ({1'b0, in_y} <  ({1'b0, act_y} + DIM_EXT));
  assign hit      = shown && in_win_x && in_win_y;
  assign dx       = CUR_BITS'(in_x - act_x);
  assign dy       = CUR_BITS'(in_y - act_y);

  logic [WORD_W-1:0] rd_word;
  logic              rd_alpha;

  cursor_store #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_store (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(img_we), .wr_id(img_id), .wr_addr(img_addr), .wr_data(img_data),
    .wr_fmt(img_fmt),
    .rd_en(in_valid), .rd_id(act_id), .rd_addr({dy, dx}),
    .rd_data(rd_word), .rd_fmt(rd_alpha)
  );

  logic               s1_valid_q;
  logic               s1_hit_q;
  logic [COORD_W-1:0] s1_x_q, s1_y_q;
  logic [PIX_W-1:0]   s1_bg_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) s1_valid_q <= 1'b0;
    else          s1_valid_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_hit_q <= hit;
      s1_x_q   <= in_x;
      s1_y_q   <= in_y;
      s1_bg_q  <= in_pix;
    end
  end

  logic [PIX_W-1:0] mix_pix;

  cursor_blend u_blend (
    .bg(s1_bg_q), .word(rd_word), .alpha_fmt(rd_alpha), .hit(s1_hit_q),
    .pix(mix_pix)
  );

  logic               s2_valid_q;
  logic [COORD_W-1:0] s2_x_q, s2_y_q;
  logic [PIX_W-1:0]   s2_pix_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) s2_valid_q <= 1'b0;
    else          s2_valid_q <= s1_valid_q;
  end

  always_ff @(posedge clk) begin
    if (s1_valid_q) begin
      s2_x_q   <= s1_x_q;
      s2_y_q   <= s1_y_q;
      s2_pix_q <= mix_pix;
    end
  end

  assign out_valid = s2_valid_q;
  assign out_x     = s2_x_q;
  assign out_y     = s2_y_q;
  assign out_pix   = s2_pix_q;
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [1:0]         reg_sel,
  input logic [WORD_W-1:0]  reg_wdata,
  input logic               in_valid,
  input logic [COORD_W-1:0] in_x,
  input logic [COORD_W-1:0] in_y,
  input logic [PIX_W-1:0]   in_pix,
  input logic               out_valid,
  input logic [COORD_W-1:0] out_x,
  input logic [COORD_W-1:0] out_y,
  input logic [PIX_W-1:0]   out_pix,
  input logic               shown
);
  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  assert_idle_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  assert_coord_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 (out_x == $past(in_x, 2) && out_y == $past(in_y, 2)));

  assert_hidden_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !shown && !$past(shown) && !$past(shown, 2))
      |-> out_pix == $past(in_pix, 2));

  assert_show_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CTL && reg_wdata == CTL_SHOW) |=> shown);

  assert_hide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CTL && reg_wdata == CTL_HIDE) |=> !shown);

  assert_other_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CTL && reg_wdata != CTL_SHOW && reg_wdata != CTL_HIDE)
      |=> $stable(shown));

  assert_staging_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel != SEL_CTL) |=> $stable(shown));
endmodule

bind cursor_overlay cursor_overlay_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
  .in_pix(in_pix), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
  .out_pix(out_pix), .shown(shown)
);

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
  localparam int CW = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        img_we;
  logic [0:0]  img_id;
  logic [9:0]  img_addr;
  logic [31:0] img_data;
  logic        img_fmt;
  logic        in_valid;
  logic [CW-1:0] in_x, in_y;
  logic [23:0] in_pix;
  logic        out_valid;
  logic [CW-1:0] out_x, out_y;
  logic [23:0] out_pix;

  cursor_overlay #(.COORD_W(CW), .NUM_IDS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .img_we(img_we), .img_id(img_id),
    .img_addr(img_addr), .img_data(img_data), .img_fmt(img_fmt),
    .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_pix(out_pix)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  bit override_w = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // bench model of the cursor state
  int s_id = 0, s_x = 0, s_y = 0;
  int m_id = 0, m_x = 0, m_y = 0;
  bit m_shown = 0;

  logic [23:0] q_pix[$];
  int          q_x[$];
  int          q_y[$];
  int          q_cyc[$];
  string       q_tag[$];

  function automatic logic [31:0] pattern(int id, int dx, int dy);
    logic [7:0] a;
    logic [7:0] r, g;
    if (id == 0) begin
      if (override_w && dx == 15 && dy == 5) return 32'h0;
      return {30'b0, dy[0], dx[0]};
    end
    a = (dx == 31) ? 8'd255 : 8'(dx * 8);
    r = 8'(dy * 8);
    g = 8'(dx * 4);
    return {a, r, g, 8'hA5};
  endfunction

  function automatic logic [7:0] mix(logic [7:0] a, logic [7:0] c, logic [7:0] b);
    int t;
    t = int'(a) * int'(c) + (255 - int'(a)) * int'(b) + 128;
    return 8'((t >> 8) & 255);
  endfunction

  function automatic logic [23:0] model(int x, int y, logic [23:0] bg);
    int dx, dy;
    logic [31:0] w;
    logic [23:0] r;
    dx = x - m_x;
    dy = y - m_y;
    if (!m_shown || dx < 0 || dx > 31 || dy < 0 || dy > 31) return bg;
    w = pattern(m_id, dx, dy);
    if (m_id == 0) return (bg & {24{w[0]}}) ^ {24{w[1]}};
    for (int c = 0; c < 3; c++) r[c*8 +: 8] = mix(w[31:24], w[c*8 +: 8], bg[c*8 +: 8]);
    return r;
  endfunction

  task automatic wr_reg(input int sel, input int data);
    @(negedge clk);
    in_valid  = 1'b0;
    reg_we    = 1'b1;
    reg_sel   = 2'(sel);
    reg_wdata = 32'(data);
    case (sel)
      0: s_id = data & 1;
      1: s_x  = data;
      2: s_y  = data;
      default: begin
        if (data == 1) begin
          m_id = s_id; m_x = s_x; m_y = s_y; m_shown = 1;
        end else if (data == 0) begin
          m_shown = 0;
        end
      end
    endcase
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pix(input int x, input int y, input logic [23:0] bg, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_x     = CW'(x);
    in_y     = CW'(y);
    in_pix   = bg;
    q_pix.push_back(model(x, y, bg));
    q_x.push_back(x);
    q_y.push_back(y);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      checks++;
      if (q_pix.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected output pixel pix=%h expected none", out_pix);
      end else begin
        logic [23:0] ep;
        int ex, ey, ec;
        string t;
        ep = q_pix.pop_front();
        ex = q_x.pop_front();
        ey = q_y.pop_front();
        ec = q_cyc.pop_front();
        t  = q_tag.pop_front();
        if (out_pix !== ep) begin
          fails++;
          $display("FAIL %s: pixel at (%0d,%0d) actual %h expected %h", t, ex, ey, out_pix, ep);
        end
        if (int'(out_x) != ex || int'(out_y) != ey) begin
          fails++;
          $display("FAIL R1: coords actual (%0d,%0d) expected (%0d,%0d)", out_x, out_y, ex, ey);
        end
        if (cyc - ec != 2) begin
          fails++;
          $display("FAIL R1: latency actual %0d expected 2", cyc - ec);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    img_we = 0; img_id = 0; img_addr = 0; img_data = 0; img_fmt = 0;
    in_valid = 0; in_x = 0; in_y = 0; in_pix = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid in reset actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid after reset actual %b expected 0", out_valid);
    end

    // R10: load both images, id 0 monochrome, id 1 alpha
    for (int id = 0; id < 2; id++) begin
      for (int a = 0; a < 1024; a++) begin
        @(negedge clk);
        img_we   = 1'b1;
        img_id   = 1'(id);
        img_addr = 10'(a);
        img_data = pattern(id, a % 32, a / 32);
        img_fmt  = (id == 1);
      end
    end
    @(negedge clk);
    img_we = 1'b0;

    // R2: hidden after reset
    pix(0, 0, 24'h123456, "R2");
    pix(100, 50, 24'hABCDEF, "R2");
    idle(3);

    // R3: staged values alone change nothing
    wr_reg(0, 0); wr_reg(1, 100); wr_reg(2, 50);
    pix(100, 50, 24'h5A5A5A, "R3");
    idle(3);

    // R4 / R8: show monochrome cursor
    wr_reg(3, 1);
    pix(100, 50, 24'h13579B, "R4");
    pix(101, 50, 24'h13579B, "R8");
    pix(100, 51, 24'h13579B, "R8");
    pix(101, 51, 24'h13579B, "R8");
    pix(131, 81, 24'h2468AC, "R8");
    idle(1);
    // R7: just outside each edge
    pix(99, 50, 24'h111111, "R7");
    pix(132, 50, 24'h222222, "R7");
    pix(100, 82, 24'h333333, "R7");
    pix(100, 49, 24'h444444, "R7");
    idle(3);

    // R3: restage X while shown, no control write
    wr_reg(1, 200);
    pix(101, 51, 24'h0F0F0F, "R3");
    pix(200, 50, 24'h0F0F0F, "R3");
    idle(3);

    // R6: frame-memory codes and unknown codes leave state alone
    wr_reg(3, 2);
    pix(101, 51, 24'hC0FFEE, "R6");
    wr_reg(3, 3);
    pix(101, 51, 24'hC0FFEE, "R6");
    pix(200, 50, 24'hC0FFEE, "R6");
    wr_reg(3, 7);
    pix(100, 51, 24'h010203, "R6");
    idle(3);

    // R9: alpha cursor
    wr_reg(0, 1); wr_reg(1, 10); wr_reg(2, 20); wr_reg(3, 1);
    pix(10, 20, 24'h8090A0, "R9");
    pix(41, 20, 24'h8090A0, "R9");
    pix(25, 23, 24'h8090A0, "R9");
    pix(26, 40, 24'hFF00FF, "R9");
    idle(3);

    // R5: hide
    wr_reg(3, 0);
    pix(25, 23, 24'h8090A0, "R5");
    pix(10, 20, 24'h777777, "R5");
    idle(3);

    // R7: clipping at the last coordinate, no wrap
    wr_reg(0, 0); wr_reg(1, 4080); wr_reg(2, 0); wr_reg(3, 1);
    pix(4095, 5, 24'h3C3C3C, "R7");
    pix(3, 5, 24'h3C3C3C, "R7");
    idle(3);

    // R10: overwrite one word of id 0 while idle
    @(negedge clk);
    img_we = 1'b1; img_id = 1'b0; img_addr = 10'(5 * 32 + 15);
    img_data = 32'h0; img_fmt = 1'b0;
    override_w = 1;
    @(negedge clk);
    img_we = 1'b0;
    pix(4095, 5, 24'h3C3C3C, "R10");
    pix(4094, 5, 24'h3C3C3C, "R10");
    idle(4);

    checks++;
    if (q_pix.size() != 0) begin
      fails++;
      $display("FAIL R1: pending outputs actual %0d expected 0", q_pix.size());
    end
    finish_run();
  end
endmodule